// File: doc/BRIEF.md
# Wear-Adaptive Refresh Interval Scheduler

This block decides when each flash block in a small set must be refreshed. For every block it keeps two counters. One counts the program/erase cycles the block has endured. The other counts the time ticks since the block was last rewritten. The wear count selects a band, and each band has its own refresh interval. Blocks that are still young fall into a band that never needs refresh. As wear grows, a block climbs through four bands whose intervals get shorter at each step. A typical ladder runs from a few years down to a few days. Each band is sized so that the raw error rate stays within what a weak ECC can correct.

When a block's age reaches the interval of its band, the block becomes due. Due blocks are offered one at a time on a request port, in round-robin order of block index. The refresh engine rewrites all pages of the named block and then returns an acknowledge. That acknowledge restarts the block's age. An erase of a block also restarts its age and advances its wear count. The band boundaries and the band intervals come from configuration inputs, expressed as wear counts and tick counts.

Top module: `wear_refresh_sched`

## Requirements
- R1: After reset, no request is pending, and every block's wear count and age are zero.
- R2: An erase event adds one to the wear count of the addressed block only. The count saturates at its all-ones value and does not wrap.
- R3: The configuration holds four wear thresholds, with threshold k in slice k of the config. A block's band is the highest k whose threshold its wear count has reached. A block below threshold 0 is never due, however long it ages.
- R4: Each tick adds one to the age of every block, saturating at all-ones. An erase or a refresh acknowledge of a block clears that block's age, and the clear takes priority over a tick in the same cycle.
- R5: A block is due when it is in a band k and its age is at least interval k, taken from slice k of the interval config. When no request is pending and some block is due, a request naming a due block appears on the next clock edge.
- R6: Only one request is outstanding at a time. Its valid and index hold steady until done is seen, and the valid drops on that edge.
- R7: After block i is granted, the search for the next grant starts at block i+1 and wraps past the last index to 0.
- R8: A done pulse while no request is pending has no effect on any block's age or on the request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle time tick that ages every block |
| erase_vld_i | input | 1 | Erase-complete event |
| erase_idx_i | input | IDX_W | Index of the erased block |
| done_i | input | 1 | Refresh of the requested block has finished |
| thr_cfg_i | input | 4*PE_W | Four wear thresholds; slice k is threshold k |
| ivl_cfg_i | input | 4*TIME_W | Four band intervals in ticks; slice k belongs to band k |
| req_vld_o | output | 1 | Refresh request pending |
| req_idx_o | output | IDX_W | Block to refresh |

## Verification
A fault in a block's wear counter shows up as a band error. The first request for that block then arrives after the wrong number of ticks, or never arrives. Nothing else shows a wrong wear count, so the bench sweeps every wear count up to and past saturation and measures the tick count to the first request. A wrong age, such as one that wraps or is not cleared, moves the request earlier or later by whole ticks, and the bench measures this within one band interval. A fault in the round-robin pointer or the hold logic changes the order or the stability of the request index within one or two cycles of an acknowledge.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  typedef enum logic [2:0] {
    BAND_NONE = 3'd0,
    BAND_0    = 3'd1,
    BAND_1    = 3'd2,
    BAND_2    = 3'd3,
    BAND_3    = 3'd4
  } band_e;

  // Highest threshold reached wins; below threshold 0 the block needs no refresh.
  function automatic band_e band_pick(input logic [31:0] wear,
                                      input logic [31:0] t0,
                                      input logic [31:0] t1,
                                      input logic [31:0] t2,
                                      input logic [31:0] t3);
    band_e b;
    if (wear >= t3)      b = BAND_3;
    else if (wear >= t2) b = BAND_2;
    else if (wear >= t1) b = BAND_1;
    else if (wear >= t0) b = BAND_0;
    else                 b = BAND_NONE;
    return b;
  endfunction

  function automatic logic [31:0] sat_inc(input logic [31:0] v,
                                          input logic [31:0] top);
    return (v >= top) ? v : v + 32'd1;
  endfunction

endpackage

// File: rtl/wrs_blk_cnt.sv
module wrs_blk_cnt
  import wrs_pkg::*;
#(
  parameter int PE_W   = 16,
  parameter int TIME_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                erase_i,
  input  logic                clear_i,
  input  logic [4*PE_W-1:0]   thr_i,
  input  logic [4*TIME_W-1:0] ivl_i,
  output logic                due_o
);

  localparam logic [31:0] PE_TOP  = 32'((64'd1 << PE_W) - 64'd1);
  localparam logic [31:0] AGE_TOP = 32'((64'd1 << TIME_W) - 64'd1);

  logic [PE_W-1:0]   wear_q;
  logic [TIME_W-1:0] age_q;
  band_e             band_w;
  logic [TIME_W-1:0] ivl_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wear_q <= '0;
      age_q  <= '0;
    end else begin
      if (erase_i) wear_q <= PE_W'(sat_inc(32'(wear_q), PE_TOP));
      if (erase_i || clear_i) age_q <= '0;
      else if (tick_i)        age_q <= TIME_W'(sat_inc(32'(age_q), AGE_TOP));
    end
  end

  assign band_w = band_pick(32'(wear_q),
                            32'(thr_i[0*PE_W +: PE_W]),
                            32'(thr_i[1*PE_W +: PE_W]),
                            32'(thr_i[2*PE_W +: PE_W]),
                            32'(thr_i[3*PE_W +: PE_W]));

  always_comb begin
    case (band_w)
      BAND_0:  ivl_sel = ivl_i[0*TIME_W +: TIME_W];
      BAND_1:  ivl_sel = ivl_i[1*TIME_W +: TIME_W];
      BAND_2:  ivl_sel = ivl_i[2*TIME_W +: TIME_W];
      BAND_3:  ivl_sel = ivl_i[3*TIME_W +: TIME_W];
      default: ivl_sel = '0;
    endcase
  end

  assign due_o = (band_w != BAND_NONE) && (age_q >= ivl_sel);

endmodule

// File: rtl/wrs_rr_pick.sv
module wrs_rr_pick #(
  parameter int NUM_BLK = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_BLK-1:0] due_i,
  input  logic [IDX_W-1:0]   start_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);

  // Walk offsets from farthest to nearest so the nearest due block wins.
  always_comb begin
    int j;
    found_o = 1'b0;
    idx_o   = '0;
    j       = 0;
    for (int k = NUM_BLK - 1; k >= 0; k--) begin
      j = int'(start_i) + k;
      if (j >= NUM_BLK) j = j - NUM_BLK;
      if (due_i[j]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/wrs_req_ctl.sv
module wrs_req_ctl #(
  parameter int NUM_BLK = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             found_i,
  input  logic [IDX_W-1:0] pick_i,
  input  logic             done_i,
  output logic             req_vld_o,
  output logic [IDX_W-1:0] req_idx_o,
  output logic [IDX_W-1:0] start_o,
  output logic             grant_o,
  output logic             ack_o
);

  function automatic logic [IDX_W-1:0] wrap_next(input logic [IDX_W-1:0] i);
    return (int'(i) >= NUM_BLK - 1) ? '0 : i + 1'b1;
  endfunction

  assign grant_o = !req_vld_o && found_i;
  assign ack_o   = req_vld_o && done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_vld_o <= 1'b0;
      req_idx_o <= '0;
      start_o   <= '0;
    end else if (ack_o) begin
      req_vld_o <= 1'b0;
    end else if (grant_o) begin
      req_vld_o <= 1'b1;
      req_idx_o <= pick_i;
      start_o   <= wrap_next(pick_i);
    end
  end

endmodule

// File: rtl/wear_refresh_sched.sv
module wear_refresh_sched #(
  parameter int NUM_BLK = 16,
  parameter int PE_W    = 16,
  parameter int TIME_W  = 24,
  localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                erase_vld_i,
  input  logic [IDX_W-1:0]    erase_idx_i,
  input  logic                done_i,
  input  logic [4*PE_W-1:0]   thr_cfg_i,
  input  logic [4*TIME_W-1:0] ivl_cfg_i,
  output logic                req_vld_o,
  output logic [IDX_W-1:0]    req_idx_o
);

  logic [NUM_BLK-1:0] due_vec_w;
  logic               found_w;
  logic [IDX_W-1:0]   pick_w;
  logic [IDX_W-1:0]   start_w;
  logic               grant_w;
  logic               ack_w;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic erase_hit;
    logic clear_hit;
    assign erase_hit = erase_vld_i && (erase_idx_i == IDX_W'(g));
    assign clear_hit = ack_w && (req_idx_o == IDX_W'(g));

    wrs_blk_cnt #(.PE_W(PE_W), .TIME_W(TIME_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .erase_i (erase_hit),
      .clear_i (clear_hit),
      .thr_i   (thr_cfg_i),
      .ivl_i   (ivl_cfg_i),
      .due_o   (due_vec_w[g])
    );
  end

  wrs_rr_pick #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_pick (
    .due_i   (due_vec_w),
    .start_i (start_w),
    .found_o (found_w),
    .idx_o   (pick_w)
  );

  wrs_req_ctl #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .found_i   (found_w),
    .pick_i    (pick_w),
    .done_i    (done_i),
    .req_vld_o (req_vld_o),
    .req_idx_o (req_idx_o),
    .start_o   (start_w),
    .grant_o   (grant_w),
    .ack_o     (ack_w)
  );

endmodule

// File: rtl/wrs_checker.sv
module wrs_checker #(
  parameter int NUM_BLK = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_vld,
  input logic [IDX_W-1:0]   req_idx,
  input logic               done,
  input logic [NUM_BLK-1:0] due_vec
);

  logic [NUM_BLK-1:0] due_q;
  always_ff @(posedge clk) begin
    if (!rst_n) due_q <= '0;
    else        due_q <= due_vec;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !done) |=> (req_vld && $stable(req_idx))); // R6

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && done) |=> !req_vld); // R6

  AST_GRANT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_vld) |-> due_q[req_idx]); // R5

  AST_DUE_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_vld && (|due_vec)) |=> req_vld); // R5

endmodule

bind wear_refresh_sched wrs_checker #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_vld (req_vld_o),
  .req_idx (req_idx_o),
  .done    (done_i),
  .due_vec (due_vec_w)
);

// File: tb/tb_wear_refresh_sched.sv
`timescale 1ns/1ps
module tb_wear_refresh_sched;

  localparam int NB = 4;
  localparam int PW = 4;
  localparam int TW = 6;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          erase_vld = 1'b0;
  logic [IW-1:0] erase_idx = '0;
  logic          done = 1'b0;
  logic [4*PW-1:0] thr_cfg;
  logic [4*TW-1:0] ivl_cfg;
  logic          req_vld;
  logic [IW-1:0] req_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  wear_refresh_sched #(.NUM_BLK(NB), .PE_W(PW), .TIME_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .erase_vld_i(erase_vld),
    .erase_idx_i(erase_idx), .done_i(done), .thr_cfg_i(thr_cfg),
    .ivl_cfg_i(ivl_cfg), .req_vld_o(req_vld), .req_idx_o(req_idx)
  );

  // Bench ladder: thresholds 2,4,6,8 and intervals 40,20,10,5 ticks.
  function automatic int exp_ivl(int erases);
    int w;
    w = (erases > 15) ? 15 : erases;
    if (w >= 8) return 5;
    if (w >= 6) return 10;
    if (w >= 4) return 20;
    if (w >= 2) return 40;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic cfg_default();
    thr_cfg = {4'd8, 4'd6, 4'd4, 4'd2};
    ivl_cfg = {6'd5, 6'd10, 6'd20, 6'd40};
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic erase1(int b);
    erase_vld = 1'b1;
    erase_idx = IW'(b);
    @(negedge clk);
    erase_vld = 1'b0;
  endtask

  task automatic ack1();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int got;
    int e;
    cfg_default();
    do_reset();
    chk(req_vld == 1'b0, "R1 reset no request", int'(req_vld), 0);

    // R2 R3 R5: sweep wear counts up to and past saturation on rotating blocks
    for (int k = 0; k <= 17; k++) begin
      int b;
      b = k % NB;
      do_reset();
      for (int n = 0; n < k; n++) erase1(b);
      got = 0;
      for (int t = 1; t <= 70; t++) begin
        tick1();
        if (req_vld) begin got = t; break; end
      end
      e = exp_ivl(k);
      chk(got == e, "R3 R5 ticks to first request", got, e);
      if (e != 0) begin
        chk(req_idx == IW'(b), "R2 request names erased block", int'(req_idx), b);
        ack1();
        chk(req_vld == 1'b0, "R6 ack drops request", int'(req_vld), 0);
      end
    end

    // R4 saturation: age beyond 63 ticks must stick at 63, not wrap
    do_reset();
    for (int t = 0; t < 70; t++) tick1();
    chk(req_vld == 1'b0, "R3 never band not requested", int'(req_vld), 0);
    thr_cfg = {4'd8, 4'd6, 4'd4, 4'd0};
    ivl_cfg = {6'd5, 6'd10, 6'd20, 6'd63};
    @(negedge clk);
    @(negedge clk);
    chk(req_vld == 1'b1, "R4 age saturates at all-ones", int'(req_vld), 1);
    cfg_default();

    // R4 erase clears age
    do_reset();
    for (int n = 0; n < 8; n++) erase1(2);
    for (int t = 0; t < 4; t++) tick1();
    chk(req_vld == 1'b0, "R5 not due before interval", int'(req_vld), 0);
    erase1(2);
    for (int t = 0; t < 4; t++) tick1();
    chk(req_vld == 1'b0, "R4 erase restarts age", int'(req_vld), 0);
    tick1();
    chk(req_vld == 1'b1 && req_idx == 2'd2, "R4 due after full interval", int'(req_idx), 2);

    // R4 R6 acknowledge clears age
    ack1();
    chk(req_vld == 1'b0, "R6 ack drops request", int'(req_vld), 0);
    for (int t = 0; t < 4; t++) tick1();
    chk(req_vld == 1'b0, "R4 ack restarts age", int'(req_vld), 0);
    tick1();
    chk(req_vld == 1'b1 && req_idx == 2'd2, "R4 due again after ack", int'(req_idx), 2);

    // R8 done with nothing pending leaves age intact
    ack1();
    for (int t = 0; t < 4; t++) tick1();
    ack1();
    @(negedge clk);
    chk(req_vld == 1'b0, "R8 stray done no request", int'(req_vld), 0);
    tick1();
    chk(req_vld == 1'b1 && req_idx == 2'd2, "R8 stray done kept age", int'(req_vld), 1);

    // R6 hold while another block is also due
    do_reset();
    for (int n = 0; n < 8; n++) begin erase1(0); erase1(1); end
    for (int t = 0; t < 5; t++) tick1();
    chk(req_vld == 1'b1 && req_idx == 2'd0, "R6 first grant", int'(req_idx), 0);
    repeat (6) @(negedge clk);
    chk(req_vld == 1'b1 && req_idx == 2'd0, "R6 request held until done", int'(req_idx), 0);

    // R7 round robin with wrap
    do_reset();
    for (int n = 0; n < 8; n++) for (int b = 0; b < NB; b++) erase1(b);
    for (int t = 0; t < 5; t++) tick1();
    chk(req_vld == 1'b1 && req_idx == 2'd0, "R7 start at block 0", int'(req_idx), 0);
    ack1();
    @(negedge clk);
    chk(req_vld == 1'b1 && req_idx == 2'd1, "R7 next block 1", int'(req_idx), 1);
    for (int t = 0; t < 5; t++) tick1();
    ack1();
    @(negedge clk);
    chk(req_vld == 1'b1 && req_idx == 2'd2, "R7 skips re-due block 0", int'(req_idx), 2);
    ack1();
    @(negedge clk);
    chk(req_vld == 1'b1 && req_idx == 2'd3, "R7 next block 3", int'(req_idx), 3);
    ack1();
    @(negedge clk);
    chk(req_vld == 1'b1 && req_idx == 2'd0, "R7 wraps to block 0", int'(req_idx), 0);
    ack1();
    @(negedge clk);
    chk(req_vld == 1'b0, "R7 nothing left due", int'(req_vld), 0);

    summary();
  end

endmodule